// File: doc/BRIEF.md
# Stored-Image Configuration Loader

This block loads configuration images that are already held in a local read-only store into a set of downstream reconfigurable devices. The host does not stream the bitstream. It issues a single request that names where the image starts, how many words it has and which device is the target. A sequencer then reads the words from the store and serializes them. It drives a serial data line, a configuration clock and an enable towards the devices, and returns a busy level and a done pulse to the host.

The block supports two wiring topologies, chosen per request. In chain mode the devices are daisy-chained. Data enters device 0 and ripples through each device's output into the next one. Clock and enable go to every device, and the length of the load is the sum of the per-device image lengths. In selected mode the serial stream, clock and enable are steered to one device only, and the other devices see all three lines held low.

Top module: `cfg_loader`

## Requirements
- R1: While reset is high and in the first cycle after it is released, busy, done, err and every bit of cfg_clk, cfg_en and cfg_dat are 0.
- R2: A request (req_valid high while busy is low and not rejected under R8) makes busy read 1 in the cycle after it is sampled. done is a single-cycle pulse that occurs exactly once per load, with busy still 1. busy reads 0 in the cycle after done.
- R3: Image words are read from consecutive store addresses starting at req_base, with addresses wrapping modulo 2^ADDR_W. The store word at address a holds (37*a + 90) mod 2^WORD_W.
- R4: Each word is sent MSB first, one bit per configuration clock period. A period is two system cycles, cfg_clk low then high. The data line changes only in cycles where cfg_clk is low and holds its value while cfg_clk is high.
- R5: cfg_en rises one system cycle after busy rises, which is one cycle before the first bit is presented and two cycles before the first cfg_clk high. It falls one cycle after the last cfg_clk high cycle, in the same cycle as done.
- R6: In selected mode (req_chain = 0), cfg_clk, cfg_en and cfg_dat are driven only on the bit indexed by req_target. All other bits stay 0.
- R7: In chain mode (req_chain = 1), cfg_clk and cfg_en go to every device and cfg_dat only to device 0. The load length is the sum over devices of their image lengths, where device i has i+1 words. req_len and req_target are ignored.
- R8: In selected mode, a request with req_target >= N_DEV or req_len = 0 raises err for exactly the one cycle after it is sampled. busy stays 0 and no enable or clock is driven.
- R9: A request presented while busy is high is ignored. It neither changes the load in progress nor starts a load afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe from the host |
| req_chain | input | 1 | 1 = chain mode, 0 = selected mode |
| req_base | input | ADDR_W | Store address of the first image word |
| req_len | input | LEN_W | Image length in words (selected mode) |
| req_target | input | TGT_W | Target device index (selected mode) |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle pulse for a rejected request |
| cfg_clk | output | N_DEV | Per-device configuration clock |
| cfg_en | output | N_DEV | Per-device configuration enable |
| cfg_dat | output | N_DEV | Per-device serial configuration data |

## Verification
The bench targets word boundaries inside a load. A design that mishandles them would repeat or drop the first bit of a word, or load the next word before the store has returned it. Both faults show up as a bit mismatch at the first bit of the second word. A load whose base sits near the top of the store checks address wraparound: a design without wrap reads the wrong word after address 255. The bench also sends rejected targets, a zero length and a request that arrives mid-load. A design that lets any of these through would raise a clock on a device outside the expected set, or would produce a second done pulse.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  typedef enum logic [2:0] {
    LD_IDLE,
    LD_READ,
    LD_LEAD,
    LD_SHIFT,
    LD_FINISH
  } ld_state_e;

  // image length, in words, of device idx on the chain
  function automatic int unsigned dev_words(input int unsigned idx);
    return idx + 1;
  endfunction

  function automatic int unsigned chain_total(input int unsigned ndev);
    int unsigned acc;
    acc = 0;
    for (int unsigned i = 0; i < ndev; i++) acc += dev_words(i);
    return acc;
  endfunction

  // store content generator, truncated to the word width by the store
  function automatic logic [63:0] store_seed(input int unsigned a);
    return 64'(a * 37 + 90);
  endfunction

endpackage

// File: rtl/cfg_store.sv
module cfg_store #(
  parameter int WORD_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  output logic [WORD_W-1:0] q
);
  import cfg_loader_pkg::*;

  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      automatic logic [63:0] s = store_seed(i);
      mem[i] = s[WORD_W-1:0];
    end
  end

  always_ff @(posedge clk) q <= mem[addr];

endmodule

// File: rtl/cfg_seq.sv
module cfg_seq
  import cfg_loader_pkg::*;
#(
  parameter int N_DEV  = 4,
  parameter int WORD_W = 8,
  parameter int ADDR_W = 8,
  parameter int LEN_W  = 8,
  parameter int TGT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_chain,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [TGT_W-1:0]  req_target,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [WORD_W-1:0] rd_q,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              s_clk,
  output logic              s_en,
  output logic              s_dat,
  output logic              chain_q,
  output logic [TGT_W-1:0]  tgt_q
);

  localparam int CHAIN_WORDS = chain_total(N_DEV);
  localparam int MAX_WORDS   = (CHAIN_WORDS > (1 << LEN_W) - 1) ? CHAIN_WORDS : (1 << LEN_W) - 1;
  localparam int WC_W        = $clog2(MAX_WORDS + 1);
  localparam int BW          = $clog2(WORD_W);
  localparam logic [TGT_W-1:0] NDEV_T = TGT_W'(N_DEV);

  ld_state_e         state;
  logic [WC_W-1:0]   words_left;
  logic [BW-1:0]     bits_left;
  logic [WORD_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= LD_IDLE;
      busy       <= 1'b0;
      done       <= 1'b0;
      err        <= 1'b0;
      s_clk      <= 1'b0;
      s_en       <= 1'b0;
      s_dat      <= 1'b0;
      rd_addr    <= '0;
      words_left <= '0;
      bits_left  <= '0;
      shreg      <= '0;
      chain_q    <= 1'b0;
      tgt_q      <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      unique case (state)
        LD_IDLE: begin
          if (req_valid) begin
            if (!req_chain && (req_target >= NDEV_T || req_len == '0)) begin
              err <= 1'b1;
            end else begin
              busy       <= 1'b1;
              state      <= LD_READ;
              rd_addr    <= req_base;
              chain_q    <= req_chain;
              tgt_q      <= req_target;
              words_left <= req_chain ? WC_W'(CHAIN_WORDS) : WC_W'(req_len);
            end
          end
        end
        LD_READ: begin
          // store output for the base address is valid next cycle
          s_en  <= 1'b1;
          state <= LD_LEAD;
        end
        LD_LEAD: begin
          s_dat      <= rd_q[WORD_W-1];
          shreg      <= rd_q << 1;
          bits_left  <= BW'(WORD_W - 1);
          rd_addr    <= rd_addr + 1'b1;
          words_left <= words_left - 1'b1;
          s_clk      <= 1'b0;
          state      <= LD_SHIFT;
        end
        LD_SHIFT: begin
          if (!s_clk) begin
            s_clk <= 1'b1;
          end else if (bits_left != '0) begin
            s_clk     <= 1'b0;
            s_dat     <= shreg[WORD_W-1];
            shreg     <= shreg << 1;
            bits_left <= bits_left - 1'b1;
          end else if (words_left != '0) begin
            s_clk      <= 1'b0;
            s_dat      <= rd_q[WORD_W-1];
            shreg      <= rd_q << 1;
            bits_left  <= BW'(WORD_W - 1);
            rd_addr    <= rd_addr + 1'b1;
            words_left <= words_left - 1'b1;
          end else begin
            s_clk <= 1'b0;
            s_en  <= 1'b0;
            s_dat <= 1'b0;
            done  <= 1'b1;
            state <= LD_FINISH;
          end
        end
        LD_FINISH: begin
          busy  <= 1'b0;
          state <= LD_IDLE;
        end
        default: state <= LD_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cfg_route.sv
module cfg_route #(
  parameter int N_DEV = 4,
  parameter int TGT_W = 3
) (
  input  logic             chain_q,
  input  logic [TGT_W-1:0] tgt_q,
  input  logic             s_clk,
  input  logic             s_en,
  input  logic             s_dat,
  output logic [N_DEV-1:0] cfg_clk,
  output logic [N_DEV-1:0] cfg_en,
  output logic [N_DEV-1:0] cfg_dat
);

  for (genvar i = 0; i < N_DEV; i++) begin : g_dev
    localparam logic [TGT_W-1:0] IDX = TGT_W'(i);
    logic picked;
    logic feeds;
    assign picked = chain_q || (tgt_q == IDX);
    // on the chain only the head device takes the serial input
    assign feeds  = chain_q ? (i == 0) : (tgt_q == IDX);
    assign cfg_clk[i] = s_clk & picked;
    assign cfg_en[i]  = s_en  & picked;
    assign cfg_dat[i] = s_dat & feeds;
  end

endmodule

// File: rtl/cfg_loader.sv
module cfg_loader #(
  parameter int N_DEV  = 4,
  parameter int WORD_W = 8,
  parameter int ADDR_W = 8,
  parameter int LEN_W  = 8,
  localparam int TGT_W = $clog2(N_DEV) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_chain,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [TGT_W-1:0]  req_target,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [N_DEV-1:0]  cfg_clk,
  output logic [N_DEV-1:0]  cfg_en,
  output logic [N_DEV-1:0]  cfg_dat
);

  logic [ADDR_W-1:0] rd_addr;
  logic [WORD_W-1:0] rd_q;
  logic              s_clk, s_en, s_dat, chain_q;
  logic [TGT_W-1:0]  tgt_q;

  cfg_store #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_store (
    .clk  (clk),
    .addr (rd_addr),
    .q    (rd_q)
  );

  cfg_seq #(
    .N_DEV(N_DEV), .WORD_W(WORD_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .TGT_W(TGT_W)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_chain  (req_chain),
    .req_base   (req_base),
    .req_len    (req_len),
    .req_target (req_target),
    .rd_addr    (rd_addr),
    .rd_q       (rd_q),
    .busy       (busy),
    .done       (done),
    .err        (err),
    .s_clk      (s_clk),
    .s_en       (s_en),
    .s_dat      (s_dat),
    .chain_q    (chain_q),
    .tgt_q      (tgt_q)
  );

  cfg_route #(.N_DEV(N_DEV), .TGT_W(TGT_W)) u_route (
    .chain_q (chain_q),
    .tgt_q   (tgt_q),
    .s_clk   (s_clk),
    .s_en    (s_en),
    .s_dat   (s_dat),
    .cfg_clk (cfg_clk),
    .cfg_en  (cfg_en),
    .cfg_dat (cfg_dat)
  );

endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk #(
  parameter int N_DEV = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             done,
  input logic             err,
  input logic [N_DEV-1:0] cfg_clk,
  input logic [N_DEV-1:0] cfg_en,
  input logic [N_DEV-1:0] cfg_dat
);

  a_r2_done_in_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);

  a_r2_idle_after_done: assert property (@(posedge clk) disable iff (rst)
    done |=> (!busy && !done));

  a_r9_busy_until_done: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> busy);

  a_r8_err_stays_idle: assert property (@(posedge clk) disable iff (rst)
    err |-> (!busy && cfg_en == '0));

  a_r5_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (cfg_en == '0 && cfg_clk == '0));

  a_r5_clk_needs_en: assert property (@(posedge clk) disable iff (rst)
    (cfg_clk & ~cfg_en) == '0);

  a_r4_dat_moves_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_dat) |-> cfg_clk == '0);

  a_r6_en_fanout: assert property (@(posedge clk) disable iff (rst)
    ($countones(cfg_en) <= 1) || (cfg_en == '1));

endmodule

bind cfg_loader cfg_loader_chk #(.N_DEV(N_DEV)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .busy    (busy),
  .done    (done),
  .err     (err),
  .cfg_clk (cfg_clk),
  .cfg_en  (cfg_en),
  .cfg_dat (cfg_dat)
);

// File: tb/cfg_loader_tb.sv
`timescale 1ns/1ps
module cfg_loader_tb;

  localparam int N_DEV = 4;
  localparam int WW    = 8;
  localparam int AW    = 8;
  localparam int LW    = 8;
  localparam int TW    = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_chain = 1'b0;
  logic [AW-1:0] req_base = '0;
  logic [LW-1:0] req_len = '0;
  logic [TW-1:0] req_target = '0;
  logic busy, done, err;
  logic [N_DEV-1:0] cfg_clk, cfg_en, cfg_dat;

  always #2 clk = ~clk;

  cfg_loader #(.N_DEV(N_DEV), .WORD_W(WW), .ADDR_W(AW), .LEN_W(LW)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_chain(req_chain),
    .req_base(req_base), .req_len(req_len), .req_target(req_target),
    .busy(busy), .done(done), .err(err),
    .cfg_clk(cfg_clk), .cfg_en(cfg_en), .cfg_dat(cfg_dat)
  );

  int checks = 0, fails = 0;
  bit exp_q[$];
  int ddev = 0;
  logic [N_DEV-1:0] mask = '0;
  int cyc = 0, bits_seen = 0, done_n = 0;
  int busy_rise_c = 0, busy_fall_c = 0, en_rise_c = 0, en_fall_c = 0;
  int first_rise_c = 0, last_rise_c = 0, done_c = 0;
  bit first_pending = 1'b0;
  logic [N_DEV-1:0] p_clk = '0;
  logic p_busy = 1'b0, p_en = 1'b0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  function automatic logic [WW-1:0] img(input int a);
    return WW'((37 * (a % (1 << AW)) + 90) % (1 << WW));
  endfunction

  // monitor: pops expected bits on every rising cfg clock of the data device
  always @(negedge clk) begin
    cyc++;
    if (busy && !p_busy) busy_rise_c = cyc;
    if (!busy && p_busy) busy_fall_c = cyc;
    if ((|cfg_en) && !p_en) en_rise_c = cyc;
    if (!(|cfg_en) && p_en) en_fall_c = cyc;
    if (done) begin done_n++; done_c = cyc; end
    for (int i = 0; i < N_DEV; i++) begin
      if (cfg_clk[i] && !p_clk[i] && !mask[i])
        chk(1'b0, "R6 clock on unselected device", i, -1);
    end
    if (cfg_clk[ddev] && !p_clk[ddev]) begin
      if (first_pending) begin first_rise_c = cyc; first_pending = 1'b0; end
      last_rise_c = cyc;
      bits_seen++;
      if (exp_q.size() == 0) chk(1'b0, "R4 unexpected extra bit", bits_seen, 0);
      else begin
        automatic bit e = exp_q.pop_front();
        chk(cfg_dat[ddev] == e, "R3/R4 serial bit", int'(cfg_dat[ddev]), int'(e));
      end
      chk((cfg_dat & ~(N_DEV'(1) << ddev)) == '0, "R6/R7 data only on fed device",
          int'(cfg_dat), int'(cfg_dat & (N_DEV'(1) << ddev)));
      chk(cfg_clk == mask, "R6/R7 clock fanout", int'(cfg_clk), int'(mask));
    end
    p_clk = cfg_clk; p_busy = busy; p_en = |cfg_en;
  end

  // driver: queue expected bits, issue request, then check handshake timing
  task automatic do_load(input bit chain, input int base, input int len, input int tgt,
                         input bit poke);
    int words, nb;
    words = 0;
    if (chain) for (int i = 0; i < N_DEV; i++) words += i + 1;
    else words = len;
    nb = words * WW;
    for (int w = 0; w < words; w++) begin
      automatic logic [WW-1:0] v = img(base + w);
      for (int b = WW - 1; b >= 0; b--) exp_q.push_back(v[b]);
    end
    ddev = chain ? 0 : tgt;
    mask = chain ? '1 : (N_DEV'(1) << tgt);
    done_n = 0; bits_seen = 0; first_pending = 1'b1;
    @(negedge clk);
    req_valid = 1'b1; req_chain = chain; req_base = AW'(base);
    req_len = LW'(len); req_target = TW'(tgt);
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R2 busy after request", int'(busy), 1);
    if (poke) begin
      repeat (10) @(negedge clk);
      // R9: a chain request mid-load would clock every device if taken
      req_valid = 1'b1; req_chain = 1'b1; req_base = 8'd0; req_target = 3'd1; req_len = 8'd1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (done_n == 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R2 busy low after done", int'(busy), 0);
    chk(done_n == 1, "R2 single done pulse", done_n, 1);
    chk(bits_seen == nb, "R4/R7 bit count", bits_seen, nb);
    chk(exp_q.size() == 0, "R3 all expected bits consumed", exp_q.size(), 0);
    chk(en_rise_c == busy_rise_c + 1, "R5 enable rise after busy", en_rise_c - busy_rise_c, 1);
    chk(first_rise_c - en_rise_c == 2, "R5 enable lead", first_rise_c - en_rise_c, 2);
    chk(en_fall_c - last_rise_c == 1, "R5 enable tail", en_fall_c - last_rise_c, 1);
    chk(done_c == en_fall_c, "R5 done with enable fall", done_c, en_fall_c);
    chk(busy_fall_c == done_c + 1, "R2 busy falls after done", busy_fall_c - done_c, 1);
    if (poke) begin
      repeat (10) begin
        @(negedge clk);
        chk(busy == 1'b0 && cfg_en == '0, "R9 ignored request not started", int'(busy), 0);
      end
    end
    exp_q.delete();
  endtask

  task automatic do_reject(input int len, input int tgt);
    mask = '0;
    @(negedge clk);
    req_valid = 1'b1; req_chain = 1'b0; req_base = 8'd3; req_len = LW'(len); req_target = TW'(tgt);
    @(negedge clk);
    req_valid = 1'b0;
    chk(err == 1'b1, "R8 err pulse", int'(err), 1);
    chk(busy == 1'b0, "R8 busy stays low", int'(busy), 0);
    @(negedge clk);
    chk(err == 1'b0, "R8 err one cycle", int'(err), 0);
    repeat (5) begin
      @(negedge clk);
      chk(cfg_en == '0 && busy == 1'b0, "R8 nothing started", int'(cfg_en), 0);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog expired: actual 0 expected 1 completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({busy, done, err} == 3'b000 && cfg_clk == '0 && cfg_en == '0 && cfg_dat == '0,
        "R1 outputs in reset", int'({busy, done, err}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk({busy, done, err} == 3'b000 && cfg_en == '0 && cfg_dat == '0,
        "R1 outputs after reset", int'({busy, done, err}), 0);

    do_load(1'b0, 5, 2, 2, 1'b0);      // R6 selected device 2
    do_load(1'b0, 254, 3, 0, 1'b0);    // R3 address wrap
    do_load(1'b1, 20, 3, 5, 1'b0);     // R7 chain, len/target ignored
    do_reject(2, 4);                   // R8 target out of range
    do_reject(1, 7);                   // R8 target out of range
    do_reject(0, 1);                   // R8 zero length
    do_load(1'b0, 100, 1, 3, 1'b0);    // R4 single word
    do_load(1'b0, 7, 4, 1, 1'b1);      // R9 request while busy
    finish_run();
  end

endmodule